// File: doc/BRIEF.md
# Latched Upper-Byte Program Counter

This block holds a 21-bit program counter that addresses program memory in bytes. Software can see only the low byte directly. The two upper fields, bits 15:8 and bits 20:16, are changed through two holding latches. A write to the low byte moves both latches into the upper fields in the same clock edge. A read of the low byte copies the current upper fields back into the latches, so that software can compute a jump target and write it back.

The block also takes direct loads of a full target from branch, call and goto instructions. These loads leave the latches untouched. A sequential advance strobe moves the PC forward by one two-byte instruction word. Each cycle the arbiter picks one update kind: HOLD, LOAD, COMMIT or STEP. The PC register takes the value that kind selects. The named transitions are HOLD to LOAD on a direct load, HOLD to COMMIT on a low-byte write, and HOLD to STEP on an advance. Any kind can follow any other in the next cycle.

Top module: `pcl_unit`

## Requirements
- R1: After reset the PC, the high latch and the upper latch are all zero.
- R2: PC bit 0 is zero at all times, including after a low-byte write of an odd value and after a direct load of an odd target.
- R3: An advance with no higher-priority update adds 2 to the PC on the next edge, modulo 2^21, so 0x1FFFFE advances to 0x000000.
- R4: Register select codes are 0 for the low byte (reads PC[7:0]), 1 for the high latch (8 bits, read/write), 2 for the upper latch (keeps write data bits 4:0, reads with bits 7:5 zero), and 3, which reads zero and ignores writes. Latch writes never change the PC.
- R5: A write to select 0 sets PC[15:8] from the high latch, PC[20:16] from the upper latch and PC[7:1] from write data bits 7:1, all in one edge.
- R6: A read strobe on select 0 copies PC[15:8] into the high latch and PC[20:16] into the upper latch, taken from the PC value before that edge.
- R7: A direct load sets the PC to the target with bit 0 cleared, and it neither reads nor changes either latch.
- R8: Priority is direct load, then low-byte write, then advance. Only the winner updates the PC. When the write and read strobes are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 low byte, 1 high latch, 2 upper latch, 3 none |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers the snapshot on select 0) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| ld_valid | input | 1 | Direct load request |
| ld_target | input | 21 | Direct load target address |
| adv | input | 1 | Sequential advance strobe |
| pc | output | 21 | Program counter |

## Verification
The bench drives the wrap from 0x1FFFFE to zero. A design with the wrong carry width would show stray upper bits there. It writes odd values into the low byte and odd load targets, so a PC that keeps bit 0 is caught. It checks that a direct load leaves the latches alone and that a snapshot taken in the same cycle as a load sees the old PC. It also fires a load, a low-byte write and an advance together, so a design with the wrong priority lands on the wrong address, and it sends a combined write and read to show that the read snapshot is suppressed.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_LOAD   = 2'd1,
        UPD_COMMIT = 2'd2,
        UPD_STEP   = 2'd3
    } upd_e;

    localparam logic [1:0] SEL_LOW  = 2'd0;
    localparam logic [1:0] SEL_HI   = 2'd1;
    localparam logic [1:0] SEL_UP   = 2'd2;
endpackage

// File: rtl/pcl_arbiter.sv
module pcl_arbiter
    import pcl_pkg::*;
(
    input  logic ld_req,
    input  logic commit_req,
    input  logic step_req,
    output upd_e upd
);
    // R8: load beats commit, commit beats step
    always_comb begin
        if (ld_req)          upd = UPD_LOAD;
        else if (commit_req) upd = UPD_COMMIT;
        else if (step_req)   upd = UPD_STEP;
        else                 upd = UPD_HOLD;
    end
endmodule

// File: rtl/pcl_latches.sv
module pcl_latches #(
    parameter int BYTE_W = 8,
    parameter int UP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_up,
    input  logic              snap,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] pc_hi,
    input  logic [UP_W-1:0]   pc_up,
    output logic [BYTE_W-1:0] hi_q,
    output logic [UP_W-1:0]   up_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            up_q <= '0;
        end else if (snap) begin
            hi_q <= pc_hi;
            up_q <= pc_up;
        end else begin
            if (wr_hi) hi_q <= wdata;
            if (wr_up) up_q <= wdata[UP_W-1:0];
        end
    end

    a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (hi_q == $past(pc_hi)) && (up_q == $past(pc_up)));

    a_r7_latches_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap && !wr_hi && !wr_up) |=> $stable(hi_q) && $stable(up_q));
endmodule

// File: rtl/pcl_counter.sv
module pcl_counter
    import pcl_pkg::*;
#(
    parameter int PC_W   = 21,
    parameter int BYTE_W = 8,
    parameter int UP_W   = PC_W - 2*BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  upd_e              upd,
    input  logic [PC_W-1:0]   ld_target,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] hi_q,
    input  logic [UP_W-1:0]   up_q,
    output logic [PC_W-1:0]   pc_q
);
    localparam logic [PC_W-1:0]   STEP    = PC_W'(2);
    localparam logic [PC_W-1:0]   LSB_CLR = ~PC_W'(1);
    localparam logic [BYTE_W-1:0] BYTE_CLR = ~BYTE_W'(1);

    logic [PC_W-1:0] pc_d;

    always_comb begin
        unique case (upd)
            UPD_LOAD:   pc_d = ld_target & LSB_CLR;
            UPD_COMMIT: pc_d = {up_q, hi_q, wdata & BYTE_CLR};
            UPD_STEP:   pc_d = pc_q + STEP;
            default:    pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    a_r2_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0);

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_STEP) |=> pc_q == $past(pc_q) + STEP);

    a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_COMMIT) |=> (pc_q[PC_W-1:2*BYTE_W] == $past(up_q)) &&
                                (pc_q[2*BYTE_W-1:BYTE_W] == $past(hi_q)));

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_LOAD) |=> pc_q[PC_W-1:1] == $past(ld_target[PC_W-1:1]));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd == UPD_HOLD) |=> $stable(pc_q));
endmodule

// File: rtl/pcl_unit.sv
module pcl_unit
    import pcl_pkg::*;
#(
    parameter int PC_W   = 21,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_target,
    input  logic              adv,
    output logic [PC_W-1:0]   pc
);
    localparam int HI_LSB = BYTE_W;
    localparam int UP_LSB = 2*BYTE_W;
    localparam int UP_W   = PC_W - UP_LSB;

    logic              low_wr, low_rd, hi_wr, up_wr;
    logic [BYTE_W-1:0] hi_q;
    logic [UP_W-1:0]   up_q;
    upd_e              upd;

    // R8: a write strobe masks a simultaneous read
    assign low_wr = reg_wr && (reg_sel == SEL_LOW);
    assign hi_wr  = reg_wr && (reg_sel == SEL_HI);
    assign up_wr  = reg_wr && (reg_sel == SEL_UP);
    assign low_rd = reg_rd && !reg_wr && (reg_sel == SEL_LOW);

    pcl_arbiter u_arb (
        .ld_req     (ld_valid),
        .commit_req (low_wr),
        .step_req   (adv),
        .upd        (upd)
    );

    pcl_latches #(.BYTE_W(BYTE_W), .UP_W(UP_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (hi_wr),
        .wr_up (up_wr),
        .snap  (low_rd),
        .wdata (reg_wdata),
        .pc_hi (pc[UP_LSB-1:HI_LSB]),
        .pc_up (pc[PC_W-1:UP_LSB]),
        .hi_q  (hi_q),
        .up_q  (up_q)
    );

    pcl_counter #(.PC_W(PC_W), .BYTE_W(BYTE_W), .UP_W(UP_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .ld_target (ld_target),
        .wdata     (reg_wdata),
        .hi_q      (hi_q),
        .up_q      (up_q),
        .pc_q      (pc)
    );

    // R4: read mux, upper latch zero-extended, code 3 reads zero
    always_comb begin
        unique case (reg_sel)
            SEL_LOW: reg_rdata = pc[BYTE_W-1:0];
            SEL_HI:  reg_rdata = hi_q;
            SEL_UP:  reg_rdata = {{(BYTE_W-UP_W){1'b0}}, up_q};
            default: reg_rdata = '0;
        endcase
    end

    a_r4_latch_wr_no_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel != SEL_LOW && !ld_valid && !adv) |=> $stable(pc));

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && (hi_q == '0) && (up_q == '0));
endmodule

// File: tb/test_pcl_unit.sv
module test_pcl_unit;
    localparam int PC_W = 21;
    localparam logic [PC_W-1:0] MASK = {PC_W{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, ld_valid = 1'b0, adv = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [20:0] ld_target = '0;
    logic [20:0] pc;

    always #2 clk = ~clk;   // 250 MHz

    pcl_unit i_pcl_unit (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ld_valid(ld_valid), .ld_target(ld_target), .adv(adv), .pc(pc)
    );

    typedef struct {
        logic [20:0] pc;
        logic [7:0]  rdata;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;
    logic [20:0] m_pc = '0;
    logic [7:0]  m_hi = '0;
    logic [4:0]  m_up = '0;

    // driver: apply one cycle of stimulus at negedge, push expected state
    task automatic step(input logic [1:0] sel, input logic wr, input logic rd,
                        input logic [7:0] wd, input logic ld, input logic [20:0] tgt,
                        input logic av, input string tag);
        logic [20:0] npc;
        logic [7:0]  nhi, erd;
        logic [4:0]  nup;
        item_t       it;
        @(negedge clk);
        reg_sel = sel; reg_wr = wr; reg_rd = rd; reg_wdata = wd;
        ld_valid = ld; ld_target = tgt; adv = av;
        npc = m_pc; nhi = m_hi; nup = m_up;
        if (ld)                    npc = tgt & ~21'd1;
        else if (wr && sel == 2'd0) npc = {m_up, m_hi, wd & 8'hFE};
        else if (av)               npc = (m_pc + 21'd2) & MASK;
        if (wr && sel == 2'd1) nhi = wd;
        if (wr && sel == 2'd2) nup = wd[4:0];
        if (rd && !wr && sel == 2'd0) begin
            nhi = m_pc[15:8];
            nup = m_pc[20:16];
        end
        m_pc = npc; m_hi = nhi; m_up = nup;
        case (sel)
            2'd0:    erd = m_pc[7:0];
            2'd1:    erd = m_hi;
            2'd2:    erd = {3'b000, m_up};
            default: erd = 8'h00;
        endcase
        it.pc = m_pc; it.rdata = erd; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input logic [1:0] sel, input string tag);
        step(sel, 0, 0, 8'h00, 0, '0, 0, tag);
    endtask

    // monitor: compare one item per edge, 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_vec++;
                if (pc !== it.pc || reg_rdata !== it.rdata) begin
                    n_bad++;
                    $display("FAIL %s: pc=%06h rdata=%02h expected pc=%06h rdata=%02h",
                             it.tag, pc, reg_rdata, it.pc, it.rdata);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle(2'd0, "R1 pc after reset");
        idle(2'd1, "R1 high latch after reset");
        idle(2'd2, "R1 upper latch after reset");
        // R3 sequential advance
        for (int i = 0; i < 3; i++) step(2'd0, 0, 0, 8'h00, 0, '0, 1, "R3 advance by 2");
        // R4 latch access, pc untouched
        step(2'd1, 1, 0, 8'h12, 0, '0, 0, "R4 write high latch");
        step(2'd2, 1, 0, 8'hFF, 0, '0, 0, "R4 upper latch keeps 5 bits");
        step(2'd3, 1, 0, 8'hAA, 0, '0, 0, "R4 select 3 reads zero");
        idle(2'd1, "R4 high latch readback");
        // R5 commit, R2 odd low byte
        step(2'd0, 1, 0, 8'h35, 0, '0, 0, "R5 R2 low write commits latches");
        // R3 wrap
        step(2'd1, 1, 0, 8'hFF, 0, '0, 0, "R4 high latch FF");
        step(2'd0, 1, 0, 8'hFE, 0, '0, 0, "R5 commit to 1FFFFE");
        step(2'd0, 0, 0, 8'h00, 0, '0, 1, "R3 wrap to zero");
        // R7 direct load, odd target, latches unchanged
        step(2'd1, 0, 0, 8'h00, 1, 21'h0ABCD5, 0, "R7 R2 direct load");
        idle(2'd2, "R7 upper latch unchanged");
        // R6 snapshot
        step(2'd0, 0, 1, 8'h00, 0, '0, 0, "R6 low read snapshot");
        idle(2'd1, "R6 high latch holds BC");
        idle(2'd2, "R6 upper latch holds 0A");
        // R6 snapshot in same cycle as load sees old pc
        step(2'd0, 0, 1, 8'h00, 1, 21'h123456, 0, "R6 snapshot with load");
        idle(2'd1, "R6 high latch from old pc");
        // R8 priorities
        step(2'd0, 1, 0, 8'h40, 1, 21'h000100, 1, "R8 load beats write and advance");
        step(2'd0, 1, 0, 8'h40, 0, '0, 1, "R8 write beats advance");
        step(2'd1, 1, 0, 8'h77, 0, '0, 0, "R8 set high latch");
        step(2'd0, 1, 1, 8'h20, 0, '0, 0, "R8 write masks read");
        idle(2'd1, "R8 high latch kept after write+read");
        step(2'd2, 1, 0, 8'h03, 0, '0, 1, "R4 latch write with advance");
        idle(2'd0, "final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule